// File: doc/BRIEF.md
# Input Stability and Layer Re-enable Gate

This block sits beside a video input and decides when the incoming picture may be captured and when the mixer may show the video layer. It watches the receiver lock flag together with the active width, height and colour-space code. It treats the input as stable only while lock holds and none of the three format values has moved since the previous clock. When the input stops being stable, capture and the video layer are both dropped straight away. The output path keeps running, so background and overlay stay on screen.

When stability returns, capture restarts and the block notes the frame buffer's read counter. The video layer comes back only after that counter has moved on by a set number of frames, four by default. This flushes any old frames the triple buffer would otherwise repeat. A reconfiguration pulse from the output side, such as a sink hot-plug or a new output format, hides the layer in the same way and starts a fresh four-frame wait. It leaves capture running.

Top module: `vin_layer_gate`

## Requirements
- R1: While reset is asserted, and afterwards until the input has been stable, capture_en_o, layer_en_o and stable_o are all 0.
- R2: stable_o is 1 in the cycle after a clock edge at which lock_i was 1 and width_i, height_i and cspace_i all equalled the values sampled at the edge before.
- R3: A change of any format field lasting even one cycle, or lock_i at 0, drives stable_o, capture_en_o and layer_en_o to 0 in the cycle after that edge.
- R4: One edge after stable_o rises from the hidden state, capture_en_o becomes 1. At that same edge, rd_count_i is recorded as the flush start.
- R5: layer_en_o turns on after the first edge at which rd_count_i minus the flush start is at least FLUSH_FRAMES (4), and not before.
- R6: The read-count difference is taken modulo 2^16, so a counter wrap from 65535 to 0 neither shortens nor stalls the wait.
- R7: A reconf_i pulse while stable turns layer_en_o off in the next cycle and keeps capture_en_o at 1. It also records rd_count_i as a new flush start, including when a wait is already running.
- R8: Losing stability during a flush wait cancels it. After stability returns, a full new wait from a new flush start is needed.
- R9: layer_en_o is never 1 while capture_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Input link locked |
| width_i | input | 16 | Current active width |
| height_i | input | 16 | Current active height |
| cspace_i | input | 3 | Current colour-space code |
| rd_count_i | input | 16 | Frame buffer read-frame counter |
| reconf_i | input | 1 | Output-side reconfiguration pulse |
| capture_en_o | output | 1 | Enable for input capture |
| layer_en_o | output | 1 | Enable for the mixer video layer |
| stable_o | output | 1 | Input currently stable |

## Verification
An output-side reconfiguration pulse and a loss of input lock can arrive at the same clock edge while the layer is shown. The bench drives both in one cycle. It expects the input-loss path to win: capture, layer and status all go to 0, and no flush wait survives. After lock returns, the layer must still wait a full four frames measured from the new flush start. A second collision is a reconfiguration pulse during a flush wait. There the bench checks that the wait restarts, so a count that would have satisfied the old start does not show the layer.

// File: rtl/vin_gate_pkg.sv
package vin_gate_pkg;
    typedef enum logic [1:0] {
        GATE_HIDDEN  = 2'd0,
        GATE_FLUSH   = 2'd1,
        GATE_SHOW    = 2'd2
    } gate_state_e;
endpackage

// File: rtl/vin_fmt_watch.sv
module vin_fmt_watch #(
    parameter int WIDTH_W  = 16,
    parameter int HEIGHT_W = 16,
    parameter int CS_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_i,
    input  logic [WIDTH_W-1:0]  width_i,
    input  logic [HEIGHT_W-1:0] height_i,
    input  logic [CS_W-1:0]     cspace_i,
    output logic                stable_o
);
    localparam int FMT_W = WIDTH_W + HEIGHT_W + CS_W;

    typedef struct packed {
        logic [FMT_W-1:0] fmt;
        logic             stable;
    } watch_t;

    watch_t watch_d, watch_q;
    logic [FMT_W-1:0] fmt_now;

    assign fmt_now = {width_i, height_i, cspace_i};

    always_comb begin
        watch_d        = watch_q;
        watch_d.fmt    = fmt_now;
        watch_d.stable = lock_i && (fmt_now == watch_q.fmt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            watch_q <= '0;
        end else begin
            watch_q <= watch_d;
        end
    end

    assign stable_o = watch_q.stable;

    a_r2_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        stable_o |-> $past(lock_i));

    a_r3_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(fmt_now)) |=> !stable_o);
endmodule

// File: rtl/vin_flush_track.sv
module vin_flush_track #(
    parameter int CNT_W        = 16,
    parameter int FLUSH_FRAMES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] FLUSH_LIM = CNT_W'(FLUSH_FRAMES);

    logic [CNT_W-1:0] base_d, base_q;
    logic [CNT_W-1:0] advance;

    always_comb begin
        base_d = base_q;
        if (snap_i) begin
            base_d = count_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    // modulo difference: wrap of the counter is harmless (R6)
    assign advance = count_i - base_q;
    assign done_o  = (advance >= FLUSH_LIM);

    a_r4_snap_taken: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (base_q == $past(count_i)));
endmodule

// File: rtl/vin_layer_gate.sv
module vin_layer_gate
    import vin_gate_pkg::*;
#(
    parameter int WIDTH_W      = 16,
    parameter int HEIGHT_W     = 16,
    parameter int CS_W         = 3,
    parameter int CNT_W        = 16,
    parameter int FLUSH_FRAMES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_i,
    input  logic [WIDTH_W-1:0]  width_i,
    input  logic [HEIGHT_W-1:0] height_i,
    input  logic [CS_W-1:0]     cspace_i,
    input  logic [CNT_W-1:0]    rd_count_i,
    input  logic                reconf_i,
    output logic                capture_en_o,
    output logic                layer_en_o,
    output logic                stable_o
);
    typedef struct packed {
        gate_state_e st;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  stable_w;
    logic  snap_w;
    logic  flushed_w;

    vin_fmt_watch #(
        .WIDTH_W (WIDTH_W),
        .HEIGHT_W(HEIGHT_W),
        .CS_W    (CS_W)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (lock_i),
        .width_i (width_i),
        .height_i(height_i),
        .cspace_i(cspace_i),
        .stable_o(stable_w)
    );

    vin_flush_track #(
        .CNT_W       (CNT_W),
        .FLUSH_FRAMES(FLUSH_FRAMES)
    ) u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap_i (snap_w),
        .count_i(rd_count_i),
        .done_o (flushed_w)
    );

    always_comb begin
        gate_d = gate_q;
        snap_w = 1'b0;
        unique case (gate_q.st)
            GATE_HIDDEN: begin
                if (stable_w) begin
                    gate_d.st = GATE_FLUSH;
                    snap_w    = 1'b1;
                end
            end
            GATE_FLUSH: begin
                if (!stable_w) begin
                    gate_d.st = GATE_HIDDEN;
                end else if (reconf_i) begin
                    snap_w = 1'b1;
                end else if (flushed_w) begin
                    gate_d.st = GATE_SHOW;
                end
            end
            GATE_SHOW: begin
                if (!stable_w) begin
                    gate_d.st = GATE_HIDDEN;
                end else if (reconf_i) begin
                    gate_d.st = GATE_FLUSH;
                    snap_w    = 1'b1;
                end
            end
            default: gate_d.st = GATE_HIDDEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q.st <= GATE_HIDDEN;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign stable_o     = stable_w;
    assign capture_en_o = stable_w && (gate_q.st != GATE_HIDDEN);
    assign layer_en_o   = stable_w && (gate_q.st == GATE_SHOW);

    a_r9_layer_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        layer_en_o |-> capture_en_o);

    a_r3_show_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.st == GATE_SHOW && !stable_w) |=> (gate_q.st == GATE_HIDDEN));

    a_r5_show_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q.st == GATE_SHOW) |-> ($past(flushed_w) && $past(gate_q.st == GATE_FLUSH)));

    a_r7_reconf_rehides: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.st == GATE_SHOW && stable_w && reconf_i) |=> (gate_q.st == GATE_FLUSH));
endmodule

// File: tb/vin_layer_gate_bench.sv
module vin_layer_gate_bench;
    typedef struct packed {
        logic        lock;
        logic [15:0] w;
        logic [15:0] h;
        logic [2:0]  cs;
        logic [15:0] cnt;
        logic        rc;
        logic        cap;
        logic        lay;
        logic        stb;
    } vec_t;

    localparam int NV = 29;
    localparam logic [15:0] W0 = 16'd1920;
    localparam logic [15:0] W1 = 16'd1280;
    localparam logic [15:0] H0 = 16'd1080;

    localparam vec_t VECS [NV] = '{
        '{1'b1, W0, H0, 3'd1, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 0  R1 first sample
        '{1'b1, W0, H0, 3'd1, 16'd10, 1'b0, 1'b0, 1'b0, 1'b1}, // 1  R2
        '{1'b1, W0, H0, 3'd1, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 2  R4 start=10
        '{1'b1, W0, H0, 3'd1, 16'd13, 1'b0, 1'b1, 1'b0, 1'b1}, // 3  R5 +3
        '{1'b1, W0, H0, 3'd1, 16'd14, 1'b0, 1'b1, 1'b1, 1'b1}, // 4  R5 +4
        '{1'b1, W0, H0, 3'd1, 16'd15, 1'b0, 1'b1, 1'b1, 1'b1}, // 5  R5
        '{1'b1, W1, H0, 3'd1, 16'd15, 1'b0, 1'b0, 1'b0, 1'b0}, // 6  R3 width glitch
        '{1'b1, W0, H0, 3'd1, 16'd15, 1'b0, 1'b0, 1'b0, 1'b0}, // 7  R3
        '{1'b1, W0, H0, 3'd1, 16'd20, 1'b0, 1'b0, 1'b0, 1'b1}, // 8  R2
        '{1'b1, W0, H0, 3'd1, 16'd20, 1'b0, 1'b1, 1'b0, 1'b1}, // 9  R4 start=20
        '{1'b1, W0, H0, 3'd1, 16'd23, 1'b0, 1'b1, 1'b0, 1'b1}, // 10 R5
        '{1'b0, W0, H0, 3'd1, 16'd24, 1'b0, 1'b0, 1'b0, 1'b0}, // 11 R8 lock lost
        '{1'b1, W0, H0, 3'd1, 16'd24, 1'b0, 1'b0, 1'b0, 1'b1}, // 12 R8
        '{1'b1, W0, H0, 3'd1, 16'd24, 1'b0, 1'b1, 1'b0, 1'b1}, // 13 R8 start=24
        '{1'b1, W0, H0, 3'd1, 16'd27, 1'b0, 1'b1, 1'b0, 1'b1}, // 14 R8
        '{1'b1, W0, H0, 3'd1, 16'd28, 1'b0, 1'b1, 1'b1, 1'b1}, // 15 R8
        '{1'b1, W0, H0, 3'd1, 16'd30, 1'b1, 1'b1, 1'b0, 1'b1}, // 16 R7 start=30
        '{1'b1, W0, H0, 3'd1, 16'd33, 1'b0, 1'b1, 1'b0, 1'b1}, // 17 R7
        '{1'b1, W0, H0, 3'd1, 16'd33, 1'b1, 1'b1, 1'b0, 1'b1}, // 18 R7 restart=33
        '{1'b1, W0, H0, 3'd1, 16'd36, 1'b0, 1'b1, 1'b0, 1'b1}, // 19 R7 +3 only
        '{1'b1, W0, H0, 3'd1, 16'd37, 1'b0, 1'b1, 1'b1, 1'b1}, // 20 R7
        '{1'b1, W0, H0, 3'd2, 16'd37, 1'b0, 1'b0, 1'b0, 1'b0}, // 21 R3 cspace
        '{1'b1, W0, H0, 3'd2, 16'd37, 1'b0, 1'b0, 1'b0, 1'b1}, // 22 R2
        '{1'b1, W0, H0, 3'd2, 16'd37, 1'b0, 1'b1, 1'b0, 1'b1}, // 23 R4 start=37
        '{1'b1, W0, H0, 3'd2, 16'd40, 1'b0, 1'b1, 1'b0, 1'b1}, // 24 R5
        '{1'b1, W0, H0, 3'd2, 16'd41, 1'b0, 1'b1, 1'b1, 1'b1}, // 25 R5
        '{1'b0, W0, H0, 3'd2, 16'd41, 1'b0, 1'b0, 1'b0, 1'b0}, // 26 R3 lock
        '{1'b1, W0, H0, 3'd2, 16'd41, 1'b0, 1'b0, 1'b0, 1'b1}, // 27 R2
        '{1'b1, W0, H0, 3'd2, 16'd41, 1'b0, 1'b1, 1'b0, 1'b1}  // 28 R4
    };

    localparam string TAGS [NV] = '{
        "R1", "R2", "R4", "R5", "R5", "R5", "R3", "R3", "R2", "R4",
        "R5", "R8", "R8", "R8", "R8", "R8", "R7", "R7", "R7", "R7",
        "R7", "R3", "R2", "R4", "R5", "R5", "R3", "R2", "R4"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic [15:0] width_i = '0;
    logic [15:0] height_i = '0;
    logic [2:0]  cspace_i = '0;
    logic [15:0] rd_count_i = '0;
    logic        reconf_i = 1'b0;
    logic        capture_en_o, layer_en_o, stable_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vin_layer_gate u_vin_layer_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_i      (lock_i),
        .width_i     (width_i),
        .height_i    (height_i),
        .cspace_i    (cspace_i),
        .rd_count_i  (rd_count_i),
        .reconf_i    (reconf_i),
        .capture_en_o(capture_en_o),
        .layer_en_o  (layer_en_o),
        .stable_o    (stable_o)
    );

    task automatic check3(input string tag, input logic ec, input logic el, input logic es);
        n_checks++;
        if ({capture_en_o, layer_en_o, stable_o} !== {ec, el, es}) begin
            n_fail++;
            $display("FAIL %s: cap/lay/stb actual %b%b%b expected %b%b%b",
                     tag, capture_en_o, layer_en_o, stable_o, ec, el, es);
        end
    endtask

    // drive at falling edge, let one rising edge pass, check at next falling edge
    task automatic step(input vec_t v, input string tag);
        lock_i     = v.lock;
        width_i    = v.w;
        height_i   = v.h;
        cspace_i   = v.cs;
        rd_count_i = v.cnt;
        reconf_i   = v.rc;
        @(negedge clk);
        check3(tag, v.cap, v.lay, v.stb);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lock_i = 1'b1; width_i = W0; height_i = H0; cspace_i = 3'd1; reconf_i = 1'b0;
        repeat (3) @(negedge clk);
        check3("R1", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            step(VECS[i], TAGS[i]);
        end

        // R6: wrap of the read counter, start at 65533
        do_reset();
        step('{1'b1, W0, H0, 3'd1, 16'd65533, 1'b0, 1'b0, 1'b0, 1'b0}, "R6");
        step('{1'b1, W0, H0, 3'd1, 16'd65533, 1'b0, 1'b0, 1'b0, 1'b1}, "R6");
        step('{1'b1, W0, H0, 3'd1, 16'd65533, 1'b0, 1'b1, 1'b0, 1'b1}, "R6");
        step('{1'b1, W0, H0, 3'd1, 16'd0,     1'b0, 1'b1, 1'b0, 1'b1}, "R6");
        step('{1'b1, W0, H0, 3'd1, 16'd1,     1'b0, 1'b1, 1'b1, 1'b1}, "R6");

        // R7 with R3 collision: reconfiguration and lock loss at one edge
        step('{1'b0, W0, H0, 3'd1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0}, "R3");
        step('{1'b1, W0, H0, 3'd1, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1}, "R8");
        step('{1'b1, W0, H0, 3'd1, 16'd5, 1'b0, 1'b1, 1'b0, 1'b1}, "R8");
        step('{1'b1, W0, H0, 3'd1, 16'd8, 1'b0, 1'b1, 1'b0, 1'b1}, "R8");
        step('{1'b1, W0, H0, 3'd1, 16'd9, 1'b0, 1'b1, 1'b1, 1'b1}, "R9");

        // reconf while hidden has no effect on the outputs (R1)
        step('{1'b0, W0, H0, 3'd1, 16'd9, 1'b0, 1'b0, 1'b0, 1'b0}, "R3");
        step('{1'b0, W0, H0, 3'd1, 16'd20, 1'b1, 1'b0, 1'b0, 1'b0}, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule